// File: doc/BRIEF.md
# Execute-Stage Redirect and Squash Selector

This block sits at the end of an out-of-order execute stage. Each cycle it receives the group of instructions that finished execution, ordered oldest first, together with per-instruction flags computed elsewhere. Those flags are:

- a resolved branch that went the wrong way;
- a memory-ordering violation found by the load/store unit;
- a load that could not proceed because memory was blocked.

For every hardware thread it chooses at most one cause of redirection and builds a squash record for the front end and commit logic. The record holds the sequence number, the branch PC, the restart PC, the actual branch direction, a mispredict flag and an include-self flag.

Within one group, the oldest qualifying instruction of a thread wins and every younger instruction of that thread is ignored for redirection. Within a single instruction the three causes follow a fixed priority, and each cause fills the record in its own way.

The block also keeps two running counters of wrong branch predictions, split by predicted direction, and presents their sum. Squashed instructions in the group are not considered for redirection and are reported back as done.

Top module: `exec_redirect_sel`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every record valid bit, blocked acknowledge, done bit and counter output is zero.
- R2: A branch-mispredict cause produces, one clock after the group is presented, a record with valid=1, the instruction's sequence number, mis_pc equal to the branch PC, restart PC equal to the branch's actual next PC, mispredict=1 and include-self=0.
- R3: The taken bit of a branch record is 1 exactly when the actual next PC differs from the branch PC plus 4. Non-branch records carry taken=0 and mis_pc=0.
- R4: A memory-order cause produces a record with restart PC equal to the instruction's next PC, mispredict=0 and include-self=0.
- R5: A memory-blocked cause produces a record with restart PC equal to the load's own PC and include-self=1, and it pulses the thread's blocked-acknowledge output in the same cycle as the record. When the thread's blocked_handled input is 1, the memory-blocked flag is ignored.
- R6: Within one instruction, a branch mispredict has priority over a memory-order violation, which has priority over a memory-blocked load.
- R7: Slot 0 is the oldest. Per thread, only the oldest non-squashed instruction with any cause produces a record, and younger instructions of that thread in the same group cannot redirect.
- R8: An instruction whose squashed flag is set never produces a record, and its bit in skip_done is 1 one clock later.
- R9: Threads are selected independently. Each thread may receive its own record in the same cycle.
- R10: A record stays valid for exactly one cycle. A group without causes for a thread clears that thread's valid bit on the next cycle.
- R11: Each branch record with taken=0 increments cnt_taken_wrong. Each branch record with taken=1 increments cnt_ntaken_wrong. cnt_mispred_total equals their sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_valid | input | EXEC_WIDTH | Slot holds an executed instruction |
| slot_squashed | input | EXEC_WIDTH | Instruction was already squashed |
| slot_tid | input | EXEC_WIDTH x TID_W | Thread of each slot |
| slot_seq | input | EXEC_WIDTH x 16 | Sequence number |
| slot_pc | input | EXEC_WIDTH x 32 | Instruction PC |
| slot_next_pc | input | EXEC_WIDTH x 32 | Actual next PC |
| slot_mispred | input | EXEC_WIDTH | Branch resolved against its prediction |
| slot_order_viol | input | EXEC_WIDTH | Memory-order violation on this instruction |
| slot_mem_blocked | input | EXEC_WIDTH | Load blocked by memory |
| blocked_handled | input | NUM_THREADS | Thread's blocked condition already handled |
| sq_valid | output | NUM_THREADS | Squash record valid |
| sq_seq | output | NUM_THREADS x 16 | Record sequence number |
| sq_mis_pc | output | NUM_THREADS x 32 | Mispredicted branch PC |
| sq_restart_pc | output | NUM_THREADS x 32 | PC where fetch restarts |
| sq_taken | output | NUM_THREADS | Actual branch direction |
| sq_mispred | output | NUM_THREADS | Record caused by branch mispredict |
| sq_incl_self | output | NUM_THREADS | Squash includes the instruction itself |
| blk_ack | output | NUM_THREADS | Blocked condition now handled |
| skip_done | output | EXEC_WIDTH | Squashed slots marked executed |
| cnt_taken_wrong | output | CNT_W | Predicted-taken errors |
| cnt_ntaken_wrong | output | CNT_W | Predicted-not-taken errors |
| cnt_mispred_total | output | CNT_W | Sum of both counters |

## Verification
The assertions assume that a new group is presented every cycle and that a slot's thread number is below NUM_THREADS. They also assume that the flags of an instruction are only meaningful when its valid bit is set. The bench drives one complete group per clock after the preceding edge, always with legal thread numbers. It clears every slot between scenarios, so a group never leaks into the next check. Sequence numbers in the bench rise with slot index, matching the oldest-first ordering the block relies on.

// File: rtl/exec_redir_pkg.sv
package exec_redir_pkg;
    localparam int PC_W      = 32;
    localparam int SEQ_W     = 16;
    localparam int INSN_SIZE = 4;

    typedef enum logic [1:0] {
        CAUSE_NONE,
        CAUSE_BRANCH,
        CAUSE_ORDER,
        CAUSE_BLOCKED
    } redir_cause_e;

    typedef struct packed {
        logic             valid;
        logic [SEQ_W-1:0] seq;
        logic [PC_W-1:0]  mis_pc;
        logic [PC_W-1:0]  restart_pc;
        logic             taken;
        logic             mispred;
        logic             incl_self;
        logic             blk_ack;
    } squash_rec_t;
endpackage

// File: rtl/redir_slot_classify.sv
module redir_slot_classify
    import exec_redir_pkg::*;
(
    input  logic             valid,
    input  logic             squashed,
    input  logic             mispred,
    input  logic             order_viol,
    input  logic             mem_blocked,
    input  logic             blocked_handled,
    input  logic [SEQ_W-1:0] seq,
    input  logic [PC_W-1:0]  pc,
    input  logic [PC_W-1:0]  next_pc,
    output redir_cause_e     cause,
    output squash_rec_t      rec
);
    logic [PC_W-1:0] fall_through;

    always_comb begin
        fall_through = pc + PC_W'(INSN_SIZE);
        cause        = CAUSE_NONE;
        if (valid && !squashed) begin
            if (mispred)                             cause = CAUSE_BRANCH;
            else if (order_viol)                     cause = CAUSE_ORDER;
            else if (mem_blocked && !blocked_handled) cause = CAUSE_BLOCKED;
        end

        rec = '0;
        rec.seq = seq;
        unique case (cause)
            CAUSE_BRANCH: begin
                rec.valid      = 1'b1;
                rec.mis_pc     = pc;
                rec.restart_pc = next_pc;
                rec.taken      = (next_pc != fall_through);
                rec.mispred    = 1'b1;
            end
            CAUSE_ORDER: begin
                rec.valid      = 1'b1;
                rec.restart_pc = next_pc;
            end
            CAUSE_BLOCKED: begin
                rec.valid      = 1'b1;
                rec.restart_pc = pc;
                rec.incl_self  = 1'b1;
                rec.blk_ack    = 1'b1;
            end
            default: rec.seq = '0;
        endcase
    end
endmodule

// File: rtl/redir_thread_pick.sv
module redir_thread_pick
    import exec_redir_pkg::*;
#(
    parameter int EXEC_WIDTH = 4,
    parameter int TID_W      = 1,
    parameter int THREAD_ID  = 0
) (
    input  logic [EXEC_WIDTH-1:0][TID_W-1:0] slot_tid,
    input  squash_rec_t [EXEC_WIDTH-1:0]     slot_rec,
    output squash_rec_t                      pick
);
    logic redirected;

    always_comb begin
        pick       = '0;
        redirected = 1'b0;
        for (int i = 0; i < EXEC_WIDTH; i++) begin
            if (!redirected && slot_rec[i].valid &&
                slot_tid[i] == TID_W'(THREAD_ID)) begin
                pick       = slot_rec[i];
                redirected = 1'b1;
            end
        end
    end
endmodule

// File: rtl/redir_mispred_ctr.sv
module redir_mispred_ctr #(
    parameter int NUM_THREADS = 2,
    parameter int CNT_W       = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] br_valid,
    input  logic [NUM_THREADS-1:0] br_taken,
    output logic [CNT_W-1:0]       cnt_taken_wrong,
    output logic [CNT_W-1:0]       cnt_ntaken_wrong,
    output logic [CNT_W-1:0]       cnt_total
);
    typedef struct packed {
        logic [CNT_W-1:0] tw;
        logic [CNT_W-1:0] nw;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (br_valid[t] && !br_taken[t]) ctr_d.tw = ctr_d.tw + CNT_W'(1);
            if (br_valid[t] &&  br_taken[t]) ctr_d.nw = ctr_d.nw + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign cnt_taken_wrong  = ctr_q.tw;
    assign cnt_ntaken_wrong = ctr_q.nw;
    assign cnt_total        = ctr_q.tw + ctr_q.nw;
endmodule

// File: rtl/exec_redirect_sel.sv
module exec_redirect_sel
    import exec_redir_pkg::*;
#(
    parameter int NUM_THREADS = 2,
    parameter int EXEC_WIDTH  = 4,
    parameter int CNT_W       = 16,
    parameter int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [EXEC_WIDTH-1:0]                 slot_valid,
    input  logic [EXEC_WIDTH-1:0]                 slot_squashed,
    input  logic [EXEC_WIDTH-1:0][TID_W-1:0]      slot_tid,
    input  logic [EXEC_WIDTH-1:0][SEQ_W-1:0]      slot_seq,
    input  logic [EXEC_WIDTH-1:0][PC_W-1:0]       slot_pc,
    input  logic [EXEC_WIDTH-1:0][PC_W-1:0]       slot_next_pc,
    input  logic [EXEC_WIDTH-1:0]                 slot_mispred,
    input  logic [EXEC_WIDTH-1:0]                 slot_order_viol,
    input  logic [EXEC_WIDTH-1:0]                 slot_mem_blocked,
    input  logic [NUM_THREADS-1:0]                blocked_handled,
    output logic [NUM_THREADS-1:0]                sq_valid,
    output logic [NUM_THREADS-1:0][SEQ_W-1:0]     sq_seq,
    output logic [NUM_THREADS-1:0][PC_W-1:0]      sq_mis_pc,
    output logic [NUM_THREADS-1:0][PC_W-1:0]      sq_restart_pc,
    output logic [NUM_THREADS-1:0]                sq_taken,
    output logic [NUM_THREADS-1:0]                sq_mispred,
    output logic [NUM_THREADS-1:0]                sq_incl_self,
    output logic [NUM_THREADS-1:0]                blk_ack,
    output logic [EXEC_WIDTH-1:0]                 skip_done,
    output logic [CNT_W-1:0]                      cnt_taken_wrong,
    output logic [CNT_W-1:0]                      cnt_ntaken_wrong,
    output logic [CNT_W-1:0]                      cnt_mispred_total
);
    typedef struct packed {
        squash_rec_t [NUM_THREADS-1:0] rec;
        logic [EXEC_WIDTH-1:0]         done;
    } sel_state_t;

    sel_state_t                    state_d, state_q;
    squash_rec_t [EXEC_WIDTH-1:0]  slot_rec;
    squash_rec_t [NUM_THREADS-1:0] thread_pick;
    redir_cause_e                  slot_cause [EXEC_WIDTH];
    logic [EXEC_WIDTH-1:0]         slot_handled;
    logic [NUM_THREADS-1:0]        br_valid, br_taken;

    // Per-slot cause decode and record build
    for (genvar i = 0; i < EXEC_WIDTH; i++) begin : g_slot
        assign slot_handled[i] = blocked_handled[slot_tid[i]];

        redir_slot_classify u_cls (
            .valid           (slot_valid[i]),
            .squashed        (slot_squashed[i]),
            .mispred         (slot_mispred[i]),
            .order_viol      (slot_order_viol[i]),
            .mem_blocked     (slot_mem_blocked[i]),
            .blocked_handled (slot_handled[i]),
            .seq             (slot_seq[i]),
            .pc              (slot_pc[i]),
            .next_pc         (slot_next_pc[i]),
            .cause           (slot_cause[i]),
            .rec             (slot_rec[i])
        );
    end

    // Oldest-first selection, one per thread
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
        redir_thread_pick #(
            .EXEC_WIDTH (EXEC_WIDTH),
            .TID_W      (TID_W),
            .THREAD_ID  (t)
        ) u_pick (
            .slot_tid (slot_tid),
            .slot_rec (slot_rec),
            .pick     (thread_pick[t])
        );
    end

    always_comb begin
        state_d.rec  = thread_pick;
        state_d.done = slot_valid & slot_squashed;
        for (int t = 0; t < NUM_THREADS; t++) begin
            br_valid[t] = thread_pick[t].valid && thread_pick[t].mispred;
            br_taken[t] = thread_pick[t].taken;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            sq_valid[t]      = state_q.rec[t].valid;
            sq_seq[t]        = state_q.rec[t].seq;
            sq_mis_pc[t]     = state_q.rec[t].mis_pc;
            sq_restart_pc[t] = state_q.rec[t].restart_pc;
            sq_taken[t]      = state_q.rec[t].taken;
            sq_mispred[t]    = state_q.rec[t].mispred;
            sq_incl_self[t]  = state_q.rec[t].incl_self;
            blk_ack[t]       = state_q.rec[t].blk_ack;
        end
        skip_done = state_q.done;
    end

    redir_mispred_ctr #(
        .NUM_THREADS (NUM_THREADS),
        .CNT_W       (CNT_W)
    ) u_ctr (
        .clk              (clk),
        .rst_n            (rst_n),
        .br_valid         (br_valid),
        .br_taken         (br_taken),
        .cnt_taken_wrong  (cnt_taken_wrong),
        .cnt_ntaken_wrong (cnt_ntaken_wrong),
        .cnt_total        (cnt_mispred_total)
    );
endmodule

// File: rtl/exec_redir_sel_chk.sv
module exec_redir_sel_chk
    import exec_redir_pkg::*;
#(
    parameter int NUM_THREADS = 2,
    parameter int EXEC_WIDTH  = 4,
    parameter int CNT_W       = 16
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [EXEC_WIDTH-1:0]             slot_valid,
    input logic [EXEC_WIDTH-1:0]             slot_squashed,
    input logic [NUM_THREADS-1:0]            sq_valid,
    input logic [NUM_THREADS-1:0][PC_W-1:0]  sq_mis_pc,
    input logic [NUM_THREADS-1:0][PC_W-1:0]  sq_restart_pc,
    input logic [NUM_THREADS-1:0]            sq_taken,
    input logic [NUM_THREADS-1:0]            sq_mispred,
    input logic [NUM_THREADS-1:0]            sq_incl_self,
    input logic [NUM_THREADS-1:0]            blk_ack,
    input logic [EXEC_WIDTH-1:0]             skip_done,
    input logic [CNT_W-1:0]                  cnt_mispred_total
);
    // R10: with no instructions presented, no record appears next cycle
    assert_idle_no_record_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(|slot_valid) |=> sq_valid == '0);

    // R8: a done bit can only follow a squashed valid slot
    assert_done_from_squashed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(slot_valid & slot_squashed)) |=> skip_done == '0);

    // R11: total grows by the number of branch records it just saw
    assert_total_tracks_records_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt_mispred_total ==
                 $past(cnt_mispred_total) + CNT_W'($countones(sq_valid & sq_mispred)));

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        // R5: blocked acknowledge only accompanies an include-self record
        assert_ack_with_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
            blk_ack[t] |-> sq_valid[t] && sq_incl_self[t] && !sq_mispred[t]);

        // R2: a mispredict record never includes the branch itself
        assert_branch_excludes_self_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (sq_valid[t] && sq_mispred[t]) |-> !sq_incl_self[t]);

        // R3: direction bit agrees with the restart target
        assert_taken_matches_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (sq_valid[t] && sq_mispred[t]) |->
                (sq_taken[t] == (sq_restart_pc[t] != sq_mis_pc[t] + PC_W'(INSN_SIZE))));

        // R3: non-branch records carry no direction
        assert_nonbranch_no_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (sq_valid[t] && !sq_mispred[t]) |-> !sq_taken[t]);
    end
endmodule

bind exec_redirect_sel exec_redir_sel_chk #(
    .NUM_THREADS (NUM_THREADS),
    .EXEC_WIDTH  (EXEC_WIDTH),
    .CNT_W       (CNT_W)
) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .slot_valid        (slot_valid),
    .slot_squashed     (slot_squashed),
    .sq_valid          (sq_valid),
    .sq_mis_pc         (sq_mis_pc),
    .sq_restart_pc     (sq_restart_pc),
    .sq_taken          (sq_taken),
    .sq_mispred        (sq_mispred),
    .sq_incl_self      (sq_incl_self),
    .blk_ack           (blk_ack),
    .skip_done         (skip_done),
    .cnt_mispred_total (cnt_mispred_total)
);

// File: tb/tb_exec_redirect_sel.sv
module tb_exec_redirect_sel;
    localparam int NT = 2;
    localparam int W  = 4;
    localparam int CW = 16;
    localparam int TW = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [W-1:0]           slot_valid, slot_squashed, slot_mispred, slot_order_viol, slot_mem_blocked;
    logic [W-1:0][TW-1:0]   slot_tid;
    logic [W-1:0][15:0]     slot_seq;
    logic [W-1:0][31:0]     slot_pc, slot_next_pc;
    logic [NT-1:0]          blocked_handled;
    logic [NT-1:0]          sq_valid, sq_taken, sq_mispred, sq_incl_self, blk_ack;
    logic [NT-1:0][15:0]    sq_seq;
    logic [NT-1:0][31:0]    sq_mis_pc, sq_restart_pc;
    logic [W-1:0]           skip_done;
    logic [CW-1:0]          cnt_taken_wrong, cnt_ntaken_wrong, cnt_mispred_total;

    exec_redirect_sel #(.NUM_THREADS(NT), .EXEC_WIDTH(W), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n),
        .slot_valid(slot_valid), .slot_squashed(slot_squashed), .slot_tid(slot_tid),
        .slot_seq(slot_seq), .slot_pc(slot_pc), .slot_next_pc(slot_next_pc),
        .slot_mispred(slot_mispred), .slot_order_viol(slot_order_viol),
        .slot_mem_blocked(slot_mem_blocked), .blocked_handled(blocked_handled),
        .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_mis_pc(sq_mis_pc),
        .sq_restart_pc(sq_restart_pc), .sq_taken(sq_taken), .sq_mispred(sq_mispred),
        .sq_incl_self(sq_incl_self), .blk_ack(blk_ack), .skip_done(skip_done),
        .cnt_taken_wrong(cnt_taken_wrong), .cnt_ntaken_wrong(cnt_ntaken_wrong),
        .cnt_mispred_total(cnt_mispred_total)
    );

    int checks = 0;
    int fails  = 0;
    int exp_tw = 0;
    int exp_nw = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_rec(input string req, input int t, input logic [15:0] seq,
                           input logic [31:0] mpc, input logic [31:0] rpc,
                           input logic tk, input logic mp, input logic inc, input logic ack);
        chk({req, " valid"},   64'(sq_valid[t]), 64'd1);
        chk({req, " seq"},     64'(sq_seq[t]), 64'(seq));
        chk({req, " mis_pc"},  64'(sq_mis_pc[t]), 64'(mpc));
        chk({req, " restart"}, 64'(sq_restart_pc[t]), 64'(rpc));
        chk({req, " taken"},   64'(sq_taken[t]), 64'(tk));
        chk({req, " mispred"}, 64'(sq_mispred[t]), 64'(mp));
        chk({req, " incl"},    64'(sq_incl_self[t]), 64'(inc));
        chk({req, " ack"},     64'(blk_ack[t]), 64'(ack));
    endtask

    task automatic clear_slots();
        slot_valid = '0; slot_squashed = '0; slot_mispred = '0;
        slot_order_viol = '0; slot_mem_blocked = '0; slot_tid = '0;
        slot_seq = '0; slot_pc = '0; slot_next_pc = '0; blocked_handled = '0;
    endtask

    task automatic set_slot(input int i, input int tid, input int seq,
                            input logic [31:0] pc, input logic [31:0] npc,
                            input logic mp, input logic ov, input logic mb, input logic sq);
        slot_valid[i] = 1'b1; slot_tid[i] = TW'(tid); slot_seq[i] = 16'(seq);
        slot_pc[i] = pc; slot_next_pc[i] = npc; slot_mispred[i] = mp;
        slot_order_viol[i] = ov; slot_mem_blocked[i] = mb; slot_squashed[i] = sq;
    endtask

    // Present the group at one edge, then look one time unit later
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_counters(input string req);
        chk({req, " taken_wrong"},  64'(cnt_taken_wrong), 64'(exp_tw));
        chk({req, " ntaken_wrong"}, 64'(cnt_ntaken_wrong), 64'(exp_nw));
        chk({req, " total"},        64'(cnt_mispred_total), 64'(exp_tw + exp_nw));
    endtask

    task automatic t_reset();
        chk("R1 valid", 64'(sq_valid), 0);
        chk("R1 ack", 64'(blk_ack), 0);
        chk("R1 done", 64'(skip_done), 0);
        chk_counters("R1");
    endtask

    task automatic t_branch();
        clear_slots();
        set_slot(0, 0, 5, 32'h1000, 32'h2000, 1, 0, 0, 0);
        step();
        exp_nw++;
        chk_rec("R2 R3 taken branch", 0, 5, 32'h1000, 32'h2000, 1, 1, 0, 0);
        chk_counters("R11 after taken");
        clear_slots();
        set_slot(0, 0, 6, 32'h1000, 32'h1004, 1, 0, 0, 0);
        step();
        exp_tw++;
        chk_rec("R3 fallthrough branch", 0, 6, 32'h1000, 32'h1004, 0, 1, 0, 0);
        chk_counters("R11 after fallthrough");
    endtask

    task automatic t_order();
        clear_slots();
        set_slot(0, 0, 9, 32'h300, 32'h304, 0, 1, 0, 0);
        step();
        chk_rec("R4 order", 0, 9, 32'h0, 32'h304, 0, 0, 0, 0);
        chk_counters("R11 unchanged by order");
    endtask

    task automatic t_blocked();
        clear_slots();
        set_slot(0, 1, 12, 32'h400, 32'h404, 0, 0, 1, 0);
        step();
        chk_rec("R5 blocked", 1, 12, 32'h0, 32'h400, 0, 0, 1, 1);
        chk("R9 other thread idle", 64'(sq_valid[0]), 0);
        clear_slots();
        set_slot(0, 1, 13, 32'h400, 32'h404, 0, 0, 1, 0);
        blocked_handled[1] = 1'b1;
        step();
        chk("R5 handled ignored valid", 64'(sq_valid), 0);
        chk("R5 handled ignored ack", 64'(blk_ack), 0);
        clear_slots();
        set_slot(0, 0, 14, 32'h500, 32'h504, 0, 0, 1, 0);
        set_slot(1, 0, 15, 32'h600, 32'h604, 0, 1, 0, 0);
        blocked_handled[0] = 1'b1;
        step();
        chk_rec("R5 handled lets younger order win", 0, 15, 32'h0, 32'h604, 0, 0, 0, 0);
    endtask

    task automatic t_priority();
        clear_slots();
        set_slot(0, 0, 20, 32'h700, 32'h800, 1, 1, 1, 0);
        step();
        exp_nw++;
        chk_rec("R6 branch over others", 0, 20, 32'h700, 32'h800, 1, 1, 0, 0);
        clear_slots();
        set_slot(0, 0, 21, 32'h900, 32'h904, 0, 1, 1, 0);
        step();
        chk_rec("R6 order over blocked", 0, 21, 32'h0, 32'h904, 0, 0, 0, 0);
    endtask

    task automatic t_oldest();
        clear_slots();
        set_slot(0, 0, 30, 32'hA00, 32'hA04, 0, 0, 0, 0);
        set_slot(1, 0, 31, 32'hA04, 32'hA08, 0, 1, 0, 0);
        set_slot(2, 0, 32, 32'hA08, 32'hB00, 1, 0, 0, 0);
        set_slot(3, 0, 33, 32'hB00, 32'hB04, 0, 0, 1, 0);
        step();
        chk_rec("R7 oldest wins", 0, 31, 32'h0, 32'hA08, 0, 0, 0, 0);
        chk_counters("R7 younger branch not counted");
    endtask

    task automatic t_squashed();
        clear_slots();
        set_slot(0, 0, 40, 32'hC00, 32'hD00, 1, 0, 0, 1);
        set_slot(1, 0, 41, 32'hC04, 32'hC08, 0, 1, 0, 0);
        set_slot(2, 1, 42, 32'hC08, 32'hC0C, 0, 1, 1, 1);
        step();
        chk_rec("R8 squashed skipped", 0, 41, 32'h0, 32'hC08, 0, 0, 0, 0);
        chk("R8 squashed thread1 no record", 64'(sq_valid[1]), 0);
        chk("R8 done mask", 64'(skip_done), 64'b0101);
        chk_counters("R8 squashed branch not counted");
    endtask

    task automatic t_threads();
        clear_slots();
        set_slot(0, 1, 50, 32'hE00, 32'hE04, 1, 0, 0, 0);
        set_slot(1, 0, 51, 32'hE10, 32'hE14, 0, 1, 0, 0);
        set_slot(2, 1, 52, 32'hE20, 32'hE24, 0, 1, 0, 0);
        set_slot(3, 0, 53, 32'hE30, 32'hF00, 1, 0, 0, 0);
        step();
        exp_tw++;
        chk_rec("R9 thread0", 0, 51, 32'h0, 32'hE14, 0, 0, 0, 0);
        chk_rec("R9 thread1", 1, 50, 32'hE00, 32'hE04, 0, 1, 0, 0);
        chk_counters("R11 two threads");
    endtask

    task automatic t_one_cycle();
        clear_slots();
        set_slot(0, 0, 60, 32'h100, 32'h200, 1, 0, 0, 0);
        set_slot(1, 1, 61, 32'h104, 32'h108, 1, 0, 0, 0);
        step();
        exp_nw++;
        exp_tw++;
        chk("R10 both valid", 64'(sq_valid), 64'b11);
        clear_slots();
        set_slot(0, 0, 62, 32'h200, 32'h204, 0, 0, 0, 0);
        step();
        chk("R10 cleared next cycle", 64'(sq_valid), 0);
        chk("R10 done cleared", 64'(skip_done), 0);
        chk_counters("R11 final");
    endtask

    initial begin
        clear_slots();
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_branch();
        t_order();
        t_blocked();
        t_priority();
        t_oldest();
        t_squashed();
        t_threads();
        t_one_cycle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule